// File: doc/BRIEF.md
# Shared-Memory Command Ring Reader

This block drains graphics commands that a host deposits into a circular buffer of 32-bit words in a shared memory. The block keeps no private head or tail registers. Both ring limits and both pointers sit in four header words at the bottom of the same memory. On every poll the block fetches those words again, so it always sees the host's latest write position. When the ring holds data, it fetches one opcode and the argument words that opcode needs. It then stores its advanced read position back into the header and offers the decoded command on a valid/ready port.

The memory is reached through one synchronous word-addressed port. Read data returns on the cycle after the request. The block has at most one access outstanding. Positions are byte offsets from the start of the region. The read position wraps from the upper limit back to the lower limit, and this may happen in the middle of a command. An opcode outside the supported rectangle set stops the block until reset.

Top module: `cmd_ring_reader`

## Requirements
- R1: The header occupies word indices 0 (lower limit), 1 (upper limit), 2 (host write position) and 3 (block read position), and all four are fetched again before each command is taken, so a host write to word 2 is picked up without any other signal.
- R2: Every limit and position is a word-aligned byte offset, and the block reads the ring word at index offset>>2.
- R3: When the read position equals the host write position, the ring is empty: no command is presented and no write is made to memory.
- R4: After the block reads the word at position p, the position becomes p+4, or the lower limit if p+4 equals the upper limit; this holds for opcode and argument words alike.
- R5: Opcode 1 (update) carries 4 argument words, opcode 2 (fill) carries 5 and opcode 3 (copy) carries 6; cmdOp shows the opcode, cmdArgCnt the count, argument k appears at cmdArgs bits [32k+31:32k], and unused argument slots read zero.
- R6: The only write the block makes goes to word index 3, carries the position just past the command's last argument word, and happens in the cycle directly before cmdValid rises.
- R7: cmdValid stays high, with cmdOp, cmdArgs and cmdArgCnt unchanged, until cmdReady is seen high; no memory access happens while it is high.
- R8: An opcode of 0 or above 3 sets errFlag, which stays set until reset; after that no command is presented and memory is neither read nor written.
- R9: While reset is asserted and right after it, cmdValid and errFlag are low and memory is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memReq | output | 1 | Memory access request this cycle |
| memWe | output | 1 | Access is a write (with memReq) |
| memAddr | output | AW | Word index of the access |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data, valid the cycle after a read request |
| cmdValid | output | 1 | Decoded command available |
| cmdReady | input | 1 | Consumer accepts the command |
| cmdOp | output | 2 | Opcode of the presented command |
| cmdArgs | output | 6*DW | Argument words, argument k in slot k |
| cmdArgCnt | output | 3 | Number of valid argument words |
| errFlag | output | 1 | Sticky unknown-opcode error |

## Verification
Wrap-around and command assembly happen together: the position can jump back to the lower limit on the very step that fetches an opcode or a middle argument, and the write-back then carries the wrapped value. The bench provokes this with a ring of 19 words and commands of 5, 6 and 7 words, run sixty times in a row, so that the wrap lands on every offset inside a command. It judges each command by comparing all six argument slots with its own host-side copy, and it checks that word 3 holds a read position it computes independently with the same wrap arithmetic.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

  localparam int MAX_ARGS = 6;
  localparam int CNT_W    = 3;

  localparam logic [1:0] OP_UPDATE = 2'd1;
  localparam logic [1:0] OP_FILL   = 2'd2;
  localparam logic [1:0] OP_COPY   = 2'd3;

  typedef enum logic [1:0] {
    ADDR_HDR,
    ADDR_RING,
    ADDR_STOP
  } addrSel_e;

  typedef struct packed {
    logic     memReq;
    logic     memWe;
    addrSel_e addrSel;
    logic     capHdr;
    logic     capOp;
    logic     capArg;
    logic     advPos;
  } ctrlStrobe_t;

  function automatic logic [CNT_W-1:0] argsFor(input logic [1:0] op);
    case (op)
      OP_UPDATE: argsFor = 3'd4;
      OP_FILL:   argsFor = 3'd5;
      OP_COPY:   argsFor = 3'd6;
      default:   argsFor = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/crb_datapath.sv
module crb_datapath
  import cmd_ring_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [1:0]             hdrSel,
  input  logic [DW-1:0]          memRdata,
  output logic [AW-1:0]          memAddr,
  output logic [DW-1:0]          memWdata,
  output logic                   ringEmpty,
  output logic                   opKnown,
  output logic                   lastArg,
  output logic [1:0]             cmdOp,
  output logic [MAX_ARGS*DW-1:0] cmdArgs,
  output logic [CNT_W-1:0]       cmdArgCnt
);

  localparam int POS_W = AW + 2;

  logic [POS_W-1:0] minPos, maxPos, nextPos, rdPos;
  logic [POS_W-1:0] stepPos, posAfter;
  logic [1:0]       opReg;
  logic [CNT_W-1:0] argNeed, argIdx;

  assign stepPos  = rdPos + POS_W'(4);
  assign posAfter = (stepPos == maxPos) ? minPos : stepPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      minPos  <= '0;
      maxPos  <= '0;
      nextPos <= '0;
      rdPos   <= '0;
    end else if (strobe.capHdr) begin
      case (hdrSel)
        2'd0:    minPos  <= memRdata[POS_W-1:0];
        2'd1:    maxPos  <= memRdata[POS_W-1:0];
        2'd2:    nextPos <= memRdata[POS_W-1:0];
        default: rdPos   <= memRdata[POS_W-1:0];
      endcase
    end else if (strobe.advPos) begin
      rdPos <= posAfter;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= '0;
      argNeed <= '0;
      argIdx  <= '0;
    end else if (strobe.capOp) begin
      opReg   <= memRdata[1:0];
      argNeed <= argsFor(memRdata[1:0]);
      argIdx  <= '0;
    end else if (strobe.capArg) begin
      argIdx  <= argIdx + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < MAX_ARGS; i++) begin : g_arg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cmdArgs[i*DW +: DW] <= '0;
      else if (strobe.capOp)
        cmdArgs[i*DW +: DW] <= '0;
      else if (strobe.capArg && argIdx == CNT_W'(i))
        cmdArgs[i*DW +: DW] <= memRdata;
    end
  end

  always_comb begin
    case (strobe.addrSel)
      ADDR_RING: memAddr = rdPos[POS_W-1:2];
      ADDR_STOP: memAddr = AW'(3);
      default:   memAddr = AW'(hdrSel);
    endcase
  end

  assign memWdata  = DW'(rdPos);
  assign ringEmpty = (rdPos == nextPos);
  assign opKnown   = (memRdata != '0) && (memRdata < DW'(4));
  assign lastArg   = (argIdx == argNeed - CNT_W'(1));
  assign cmdOp     = opReg;
  assign cmdArgCnt = argNeed;

endmodule

// File: rtl/crb_control.sv
module crb_control
  import cmd_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ringEmpty,
  input  logic        opKnown,
  input  logic        lastArg,
  input  logic        cmdReady,
  output ctrlStrobe_t strobe,
  output logic [1:0]  hdrSel,
  output logic        cmdValid,
  output logic        errFlag
);

  typedef enum logic [3:0] {
    S_HREQ, S_HCAP, S_CHECK, S_OREQ, S_OCAP,
    S_AREQ, S_ACAP, S_WB, S_SHOW, S_ERR
  } state_e;

  state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_HREQ;
      hdrSel <= '0;
    end else begin
      state <= stateNxt;
      if (state == S_HCAP) hdrSel <= hdrSel + 2'd1;
    end
  end

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    case (state)
      S_HREQ: begin
        strobe.memReq = 1'b1;
        stateNxt      = S_HCAP;
      end
      S_HCAP: begin
        strobe.capHdr = 1'b1;
        stateNxt      = (hdrSel == 2'd3) ? S_CHECK : S_HREQ;
      end
      S_CHECK: stateNxt = ringEmpty ? S_HREQ : S_OREQ;
      S_OREQ: begin
        strobe.memReq  = 1'b1;
        strobe.addrSel = ADDR_RING;
        stateNxt       = S_OCAP;
      end
      S_OCAP: begin
        strobe.capOp  = 1'b1;
        strobe.advPos = opKnown;
        stateNxt      = opKnown ? S_AREQ : S_ERR;
      end
      S_AREQ: begin
        strobe.memReq  = 1'b1;
        strobe.addrSel = ADDR_RING;
        stateNxt       = S_ACAP;
      end
      S_ACAP: begin
        strobe.capArg = 1'b1;
        strobe.advPos = 1'b1;
        stateNxt      = lastArg ? S_WB : S_AREQ;
      end
      S_WB: begin
        strobe.memReq  = 1'b1;
        strobe.memWe   = 1'b1;
        strobe.addrSel = ADDR_STOP;
        stateNxt       = S_SHOW;
      end
      S_SHOW:  if (cmdReady) stateNxt = S_HREQ;
      default: stateNxt = S_ERR;
    endcase
  end

  assign cmdValid = (state == S_SHOW);
  assign errFlag  = (state == S_ERR);

endmodule

// File: rtl/cmd_ring_reader.sv
module cmd_ring_reader
  import cmd_ring_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  output logic                   memReq,
  output logic                   memWe,
  output logic [AW-1:0]          memAddr,
  output logic [DW-1:0]          memWdata,
  input  logic [DW-1:0]          memRdata,
  output logic                   cmdValid,
  input  logic                   cmdReady,
  output logic [1:0]             cmdOp,
  output logic [MAX_ARGS*DW-1:0] cmdArgs,
  output logic [CNT_W-1:0]       cmdArgCnt,
  output logic                   errFlag
);

  ctrlStrobe_t strobe;
  logic [1:0]  hdrSel;
  logic        ringEmpty, opKnown, lastArg;

  crb_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ringEmpty (ringEmpty),
    .opKnown   (opKnown),
    .lastArg   (lastArg),
    .cmdReady  (cmdReady),
    .strobe    (strobe),
    .hdrSel    (hdrSel),
    .cmdValid  (cmdValid),
    .errFlag   (errFlag)
  );

  crb_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hdrSel    (hdrSel),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .ringEmpty (ringEmpty),
    .opKnown   (opKnown),
    .lastArg   (lastArg),
    .cmdOp     (cmdOp),
    .cmdArgs   (cmdArgs),
    .cmdArgCnt (cmdArgCnt)
  );

  assign memReq = strobe.memReq;
  assign memWe  = strobe.memWe;

endmodule

// File: rtl/crb_checker.sv
module crb_checker
  import cmd_ring_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 32
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   memReq,
  input logic                   memWe,
  input logic [AW-1:0]          memAddr,
  input logic                   cmdValid,
  input logic                   cmdReady,
  input logic [1:0]             cmdOp,
  input logic [MAX_ARGS*DW-1:0] cmdArgs,
  input logic [CNT_W-1:0]       cmdArgCnt,
  input logic                   errFlag
);

  a_r6_write_only_stop: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memReq && memAddr == AW'(3)));

  a_r6_write_before_valid: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> $past(memWe));

  a_r7_hold_until_ready: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdOp) && $stable(cmdArgs) && $stable(cmdArgCnt)));

  a_r7_no_access_while_valid: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !memReq);

  a_r5_count_matches_op: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ((cmdOp == 2'd1 && cmdArgCnt == 3'd4) ||
                  (cmdOp == 2'd2 && cmdArgCnt == 3'd5) ||
                  (cmdOp == 2'd3 && cmdArgCnt == 3'd6)));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!cmdValid && !memReq));

endmodule

bind cmd_ring_reader crb_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .cmdValid  (cmdValid),
  .cmdReady  (cmdReady),
  .cmdOp     (cmdOp),
  .cmdArgs   (cmdArgs),
  .cmdArgCnt (cmdArgCnt),
  .errFlag   (errFlag)
);

// File: tb/cmd_ring_reader_bench.sv
`timescale 1ns/1ps
module cmd_ring_reader_bench;

  localparam int AW    = 8;
  localparam int DW    = 32;
  localparam int WORDS = 1 << AW;
  localparam logic [31:0] RMIN = 32'h40;
  localparam logic [31:0] RMAX = 32'h8C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;
  logic cmdValid;
  logic cmdReady = 1'b0;
  logic [1:0] cmdOp;
  logic [6*DW-1:0] cmdArgs;
  logic [2:0] cmdArgCnt;
  logic errFlag;

  logic [31:0] mem [0:WORDS-1];
  logic [31:0] expArgs [0:5];
  logic [31:0] hp, cp;
  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int writes = 0;

  always #2 clk = ~clk;

  cmd_ring_reader #(.AW(AW), .DW(DW)) u_cmd_ring_reader (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdArgs(cmdArgs),
    .cmdArgCnt(cmdArgCnt), .errFlag(errFlag)
  );

  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        writes <= writes + 1;
      end else begin
        memRdata <= mem[memAddr];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [31:0] adv(input logic [31:0] p);
    return (p + 32'd4 == RMAX) ? RMIN : p + 32'd4;
  endfunction

  function automatic int nArgs(input int op);
    return op + 3;
  endfunction

  task automatic initMem();
    for (int i = 0; i < WORDS; i++) mem[i] = 32'h0;
    mem[0] = RMIN; mem[1] = RMAX; mem[2] = RMIN; mem[3] = RMIN;
    hp = RMIN; cp = RMIN;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cmdReady = 1'b0;
    initMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // host writes one command into the ring, then publishes word 2
  task automatic push(input int op, input int seed);
    int n;
    n = (op >= 1 && op <= 3) ? nArgs(op) : 0;
    mem[hp >> 2] = op;
    hp = adv(hp);
    for (int k = 0; k < 6; k++) expArgs[k] = 32'h0;
    for (int k = 0; k < n; k++) begin
      expArgs[k] = 32'hA000_0000 + seed * 256 + k * 17;
      mem[hp >> 2] = expArgs[k];
      hp = adv(hp);
    end
    mem[2] = hp;
  endtask

  task automatic waitValid(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (cmdValid) begin seen = 1'b1; break; end
    end
  endtask

  task automatic expectCmd(input int op, input string tag);
    bit seen;
    int n;
    n = nArgs(op);
    waitValid(seen);
    check(seen, {tag, " R3 command presented"}, 32'(seen), 32'h1);
    if (seen) begin
      for (int k = 0; k < n + 1; k++) cp = adv(cp);
      check(cmdOp == 2'(op), {tag, " R5 opcode"}, 32'(cmdOp), 32'(op));
      check(cmdArgCnt == 3'(n), {tag, " R5 count"}, 32'(cmdArgCnt), 32'(n));
      for (int k = 0; k < 6; k++)
        check(cmdArgs[k*32 +: 32] == expArgs[k], {tag, " R4 R5 argument"},
              cmdArgs[k*32 +: 32], expArgs[k]);
      check(mem[3] == cp, {tag, " R6 R4 write-back"}, mem[3], cp);
      cmdReady = 1'b1;
      @(negedge clk);
      cmdReady = 1'b0;
    end
  endtask

  initial begin
    bit seen;
    logic [31:0] held;
    initMem();
    repeat (2) @(negedge clk);
    check(cmdValid == 1'b0, "R9 reset cmdValid", 32'(cmdValid), 32'h0);
    check(errFlag == 1'b0, "R9 reset errFlag", 32'(errFlag), 32'h0);
    check(writes == 0, "R9 no write in reset", 32'(writes), 32'h0);
    rstN = 1'b1;

    // R3: empty ring stays idle
    repeat (60) @(negedge clk);
    check(cmdValid == 1'b0, "R3 empty no command", 32'(cmdValid), 32'h0);
    check(writes == 0, "R3 empty no write", 32'(writes), 32'h0);

    // R1 R2: sweep, wrap lands at every offset inside a command
    for (int i = 0; i < 60; i++) begin
      push(1 + (i % 3), i);
      expectCmd(1 + (i % 3), "R1 R2 sweep");
    end

    // R7: backpressure holds the command; a queued second one waits
    push(3, 200);
    waitValid(seen);
    check(seen, "R7 first command", 32'(seen), 32'h1);
    held = cmdArgs[5*32 +: 32];
    push(2, 201);
    repeat (10) @(negedge clk);
    check(cmdValid == 1'b1, "R7 valid held", 32'(cmdValid), 32'h1);
    check(cmdOp == 2'd3, "R7 opcode held", 32'(cmdOp), 32'h3);
    check(cmdArgs[5*32 +: 32] == held, "R7 argument held", cmdArgs[5*32 +: 32], held);
    for (int k = 0; k < 7; k++) cp = adv(cp);
    check(mem[3] == cp, "R7 second not consumed", mem[3], cp);
    cmdReady = 1'b1;
    @(negedge clk);
    cmdReady = 1'b0;
    expectCmd(2, "R7 queued second");

    // R8: opcode 0 halts
    push(0, 300);
    repeat (40) @(negedge clk);
    check(errFlag == 1'b1, "R8 opcode 0 error", 32'(errFlag), 32'h1);
    check(mem[3] == cp, "R8 no write-back", mem[3], cp);
    held = 32'(writes);
    push(1, 301);
    repeat (80) @(negedge clk);
    check(cmdValid == 1'b0, "R8 no command after error", 32'(cmdValid), 32'h0);
    check(errFlag == 1'b1, "R8 error sticky", 32'(errFlag), 32'h1);
    check(32'(writes) == held, "R8 no writes after error", 32'(writes), held);

    // R9 then R8 with opcode 7
    doReset();
    @(negedge clk);
    check(errFlag == 1'b0, "R9 error cleared by reset", 32'(errFlag), 32'h0);
    push(1, 400);
    expectCmd(1, "R9 after reset");
    push(7, 401);
    repeat (40) @(negedge clk);
    check(errFlag == 1'b1, "R8 opcode 7 error", 32'(errFlag), 32'h1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule